// File: doc/BRIEF.md
# Synchronous Burst Static RAM with Byte-Lane Writes

This block models a single-port synchronous static RAM built for burst traffic. Every input is sampled on the rising clock edge: address, write data, strobes, chip enables and write controls. At each edge the block also updates the word address, performs any write, and records whether it is selected. Read data leaves the array with no output register. The word at the current address therefore appears on `dout` during the cycle that follows the edge that chose it. A word written at an edge appears there in the same way.

Two address strobes can start a burst. The processor-side strobe gives a read-only first cycle. The controller-side strobe lets a write happen in the cycle it loads. After a load, a 2-bit counter forms the two low address bits while the advance input is asserted. The counter runs in linear or interleaved order, selected by a mode pin. A write lands on each byte lane chosen by a global write input, or by a byte-write enable combined with per-lane enables.

The word count is `2**ADDR_W` and the lane width is `LANE_W`. Setting `ADDR_W=17` gives 128K words, and `LANE_W=9` gives a 36-bit word with parity lanes.

Top module: `sbs_sram`

## Requirements
- R1: After synchronous reset (`rst_n` low at an edge), `dout` reads all zeros until a strobe is accepted with the chip selected.
- R2: The chip is selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. A strobe seen while the chip is not selected deselects it, and `dout` then reads zero until the next accepted strobe.
- R3: An accepted controller strobe (`adsc_n`=0) loads `addr`, and burst count 0 is used for that edge. The cycle after that edge shows the word at `addr`. A write may take place at that same edge.
- R4: The processor strobe (`adsp_n`=0) has no effect while `ce1_n`=1. When it is accepted, that edge performs no write. When both strobes are low with `ce1_n`=0, the processor strobe's read-only load is used.
- R5: With `mode`=0 the two low address bits are the start value plus the burst count, modulo 4 (start 1 gives 1,2,3,0).
- R6: With `mode`=1 the two low address bits are the start value XOR the burst count (start 1 gives 1,0,3,2).
- R7: With no strobe and `adv_n`=1, the address is held and the same word is shown again. With `adv_n`=0 the burst count steps by one.
- R8: Lane n is `din[n*LANE_W +: LANE_W]`, with lane 0 as the lowest bits. Lane n is written when `bwe_n`=0 and `bw_n[n]`=0, and the other lanes keep their contents.
- R9: With `gw_n`=1 and `bwe_n`=1, no lane is written, whatever `bw_n` holds.
- R10: With `gw_n`=0, all lanes are written, regardless of `bwe_n` and `bw_n`.
- R11: A word written at an edge appears on `dout` in the cycle that follows that same edge (flow-through, write-through).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | External word address used on a load |
| adsp_n | input | 1 | Processor address strobe, active low, read-only load |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Chip enable 1, active low; also gates `adsp_n` |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low |
| gw_n | input | 1 | Global write, active low, all lanes |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | LANES | Per-lane write enables, active low |
| mode | input | 1 | Burst order: 0 linear, 1 interleaved |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Flow-through read data |

## Verification
The assertions watch every cycle for these properties:
- The burst count steps exactly once for each advance.
- The address holds while the block is idle.
- A load captures the external address.
- A deselect forces zero on the output.
- A global write is read back on the next cycle.
- With all write controls inactive and the address held, the output is left unchanged.

Only the bench scenarios can show the actual linear and interleaved address sequences. The same holds for the merging of partial byte writes, the read-only first cycle of a processor-strobe load, and the choice made when both strobes are low.

// File: rtl/sbs_pkg.sv
`timescale 1ns/1ps
// Package for the burst SRAM: burst order type and the low-address
// generator shared by the address unit.
package sbs_pkg;

    typedef enum logic {
        ORDER_LINEAR     = 1'b0,
        ORDER_INTERLEAVE = 1'b1
    } burst_order_e;

    // Low two address bits for a given start value and burst count.
    function automatic logic [1:0] burst_low(input logic [1:0]   start,
                                             input logic [1:0]   count,
                                             input burst_order_e ord);
        logic [1:0] res;
        if (ord == ORDER_INTERLEAVE) res = start ^ count;
        else                         res = start + count;
        return res;
    endfunction

endpackage

// File: rtl/sbs_burst_addr.sv
`timescale 1ns/1ps
// Burst address unit. It holds the loaded base address and a 2-bit burst
// count, and forms the word address from them in the selected order.
// Assumes load and step are never both high. addr_d is the address
// that the coming edge will store; addr_q is the stored one.
module sbs_burst_addr
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [ADDR_W-1:0]  ld_addr,
    input  logic               step,
    input  burst_order_e       order,
    output logic [ADDR_W-1:0]  addr_d,
    output logic [ADDR_W-1:0]  addr_q
);
    localparam int CNT_W = 2;

    logic [ADDR_W-1:0] base_q, base_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;

    // Next base and count: a load restarts, a step counts, otherwise hold.
    always_comb begin
        base_d = base_q;
        cnt_d  = cnt_q;
        if (load) begin
            base_d = ld_addr;
            cnt_d  = '0;
        end else if (step) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    // Word address built from the next base and count.
    always_comb begin
        addr_d = {base_d[ADDR_W-1:CNT_W], burst_low(base_d[CNT_W-1:0], cnt_d, order)};
    end

    // State registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
            addr_q <= '0;
        end else begin
            base_q <= base_d;
            cnt_q  <= cnt_d;
            addr_q <= addr_d;
        end
    end

    // R7
    ctr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (cnt_q == $past(cnt_q) + 2'd1));

    // R7
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(addr_q));

    // R3
    load_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (addr_q == $past(ld_addr)));

endmodule

// File: rtl/sbs_write_dec.sv
`timescale 1ns/1ps
// Write decoder. It turns the global write and the per-lane write
// controls into one write enable per byte lane. allow gates every lane.
// It covers cycles that are not read-only and a chip that is active.
module sbs_write_dec #(
    parameter int LANES = 4
) (
    input  logic             allow,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bw_n,
    output logic [LANES-1:0] lane_we
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Lane enable: global write, or byte-write enable plus own lane bit.
        always_comb begin
            lane_we[g] = allow && (!gw_n || (!bwe_n && !bw_n[g]));
        end
    end
endmodule

// File: rtl/sbs_lane_mem.sv
`timescale 1ns/1ps
// One byte lane of storage. Writes happen at the rising edge. Reads are
// combinational from raddr, so a word written at an edge is visible right
// after it whenever raddr equals that write address. Storage is not reset.
module sbs_lane_mem #(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] mem [DEPTH];

    // Edge-triggered write of one lane.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Flow-through read.
    always_comb begin
        rdata = mem[raddr];
    end
endmodule

// File: rtl/sbs_sram.sv
`timescale 1ns/1ps
// Top of the synchronous burst SRAM. It samples the strobes, chip
// enables and write controls at each rising edge. It decides load,
// deselect or advance, writes the addressed word, and drives the stored
// word out with no output register. Assumes mode changes only between
// bursts.
module sbs_sram
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 8,
    parameter int LANES  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      adsp_n,
    input  logic                      adsc_n,
    input  logic                      adv_n,
    input  logic                      ce1_n,
    input  logic                      ce2,
    input  logic                      ce3_n,
    input  logic                      gw_n,
    input  logic                      bwe_n,
    input  logic [LANES-1:0]          bw_n,
    input  logic                      mode,
    input  logic [LANES*LANE_W-1:0]   din,
    output logic [LANES*LANE_W-1:0]   dout
);
    localparam int DATA_W = LANES * LANE_W;

    logic              selected, p_strobe, any_strobe;
    logic              load, p_load, desel, step;
    logic              active_q, active_d, wr_allow;
    logic [ADDR_W-1:0] addr_d, addr_q;
    logic [LANES-1:0]  lane_we;
    logic [DATA_W-1:0] rdata;
    burst_order_e      order;

    // Strobe qualification: the processor strobe counts only with ce1 active.
    always_comb begin
        selected   = !ce1_n && ce2 && !ce3_n;
        p_strobe   = !adsp_n && !ce1_n;
        any_strobe = p_strobe || !adsc_n;
        load       = any_strobe && selected;
        p_load     = load && p_strobe;
        desel      = any_strobe && !selected;
        step       = active_q && !adv_n && !any_strobe;
        order      = burst_order_e'(mode);
    end

    // Active state after this edge, and whether a write may take place.
    always_comb begin
        if (load)       active_d = 1'b1;
        else if (desel) active_d = 1'b0;
        else            active_d = active_q;
        wr_allow = active_d && !p_load;
    end

    // Chip-active register.
    always_ff @(posedge clk) begin
        if (!rst_n) active_q <= 1'b0;
        else        active_q <= active_d;
    end

    sbs_burst_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .ld_addr (addr),
        .step    (step),
        .order   (order),
        .addr_d  (addr_d),
        .addr_q  (addr_q)
    );

    sbs_write_dec #(.LANES(LANES)) u_wdec (
        .allow   (wr_allow),
        .gw_n    (gw_n),
        .bwe_n   (bwe_n),
        .bw_n    (bw_n),
        .lane_we (lane_we)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_mem
        sbs_lane_mem #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lane (
            .clk   (clk),
            .we    (lane_we[g]),
            .waddr (addr_d),
            .wdata (din[g*LANE_W +: LANE_W]),
            .raddr (addr_q),
            .rdata (rdata[g*LANE_W +: LANE_W])
        );
    end

    // Output: stored word while active, zero while deselected.
    always_comb begin
        dout = active_q ? rdata : '0;
    end

    // R2
    desel_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        desel |=> (dout == '0));

    // R10
    gw_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_allow && !gw_n) |=> (dout == $past(din)));

    // R9
    no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gw_n && bwe_n && !any_strobe && adv_n) |=> $stable(dout));

    // R4
    adsp_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adsp_n && ce1_n && adsc_n && adv_n) |=> $stable(addr_q));

endmodule

// File: tb/sbs_sram_bench.sv
`timescale 1ns/1ps
module sbs_sram_bench;
    localparam int AW = 10;
    localparam int LW = 8;
    localparam int NL = 4;
    localparam int DW = NL * LW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          adsp_n, adsc_n, adv_n, ce1_n, ce2, ce3_n;
    logic          gw_n, bwe_n, mode;
    logic [NL-1:0] bw_n;
    logic [DW-1:0] din, dout;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    logic [DW-1:0] exp_q[$];
    string         tag_q[$];

    // Reference state built from the requirements.
    logic [DW-1:0] ref_mem [0:(1<<AW)-1];
    bit            m_act;
    logic [AW-1:0] m_base;
    logic [1:0]    m_cnt;

    always #2 clk = ~clk;

    sbs_sram #(.ADDR_W(AW), .LANE_W(LW), .LANES(NL)) u_sbs_sram (
        .clk(clk), .rst_n(rst_n), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
        .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .gw_n(gw_n),
        .bwe_n(bwe_n), .bw_n(bw_n), .mode(mode), .din(din), .dout(dout)
    );

    // Monitor: pops one expected item per edge and compares.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [DW-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (dout !== e) begin
                failures++;
                $display("FAIL %s dout=%h expected=%h", t, dout, e);
            end
        end
    end

    // Driver step: model the coming edge, push the expectation, move on.
    task automatic tick(input string tag);
        bit sel, pstr, strb, pl;
        logic [AW-1:0] a;
        if (!rst_n) begin
            m_act = 0; m_base = '0; m_cnt = '0; pl = 1'b0;
        end else begin
            sel  = !ce1_n && ce2 && !ce3_n;
            pstr = !adsp_n && !ce1_n;
            strb = pstr || !adsc_n;
            pl   = 1'b0;
            if (strb && sel) begin
                m_act = 1; m_base = addr; m_cnt = 2'd0; pl = pstr;
            end else if (strb) begin
                m_act = 0;
            end else if (m_act && !adv_n) begin
                m_cnt = m_cnt + 2'd1;
            end
        end
        a = m_base;
        a[1:0] = mode ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
        if (rst_n && m_act && !pl) begin
            for (int l = 0; l < NL; l++)
                if (!gw_n || (!bwe_n && !bw_n[l]))
                    ref_mem[a][l*LW +: LW] = din[l*LW +: LW];
        end
        exp_q.push_back(m_act ? ref_mem[a] : '0);
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    task automatic idle();
        addr = '0; adsp_n = 1; adsc_n = 1; adv_n = 1;
        ce1_n = 0; ce2 = 1; ce3_n = 0;
        gw_n = 1; bwe_n = 1; bw_n = '1; din = '0;
    endtask

    initial begin
        rst_n = 0; mode = 0;
        idle();
        @(negedge clk);
        tick("R1 reset"); tick("R1 reset");
        rst_n = 1;
        tick("R1 idle after reset");

        // R3 R10 R11: controller-strobe load with global writes, linear fill.
        addr = 10'h010; adsc_n = 0; gw_n = 0; din = 32'hA000_0000;
        tick("R3 load-write");
        adsc_n = 1; adv_n = 0;
        for (int i = 1; i < 4; i++) begin
            din = 32'hA000_0000 + i; tick("R10 burst write");
        end
        addr = 10'h014; adsc_n = 0; adv_n = 1; din = 32'hB000_0000;
        tick("R11 write-through");
        adsc_n = 1; adv_n = 0;
        for (int i = 1; i < 4; i++) begin
            din = 32'hB000_0000 + i; tick("R10 burst write");
        end
        idle(); tick("R7 hold");

        // R5: processor-strobe read, linear from start 1 with wrap.
        addr = 10'h011; adsp_n = 0; tick("R4 adsp load");
        adsp_n = 1; adv_n = 0;
        for (int i = 0; i < 4; i++) tick("R5 linear");

        // R6: interleaved order from starts 1 and 2.
        idle(); mode = 1;
        addr = 10'h011; adsp_n = 0; tick("R6 load");
        adsp_n = 1; adv_n = 0;
        for (int i = 0; i < 3; i++) tick("R6 interleave");
        idle(); addr = 10'h016; adsc_n = 0; tick("R6 load");
        adsc_n = 1; adv_n = 0;
        for (int i = 0; i < 3; i++) tick("R6 interleave");
        idle(); mode = 0;
        tick("R7 hold"); tick("R7 hold");

        // R8: partial byte write on lanes 0 and 2.
        addr = 10'h015; adsc_n = 0; bwe_n = 0; bw_n = 4'b1010; din = 32'h1122_3344;
        tick("R8 byte write");
        idle(); tick("R8 merged readback");

        // R9: lane bits without byte-write enable write nothing.
        bw_n = 4'b0000; bwe_n = 1; din = 32'hDEAD_BEEF; tick("R9 no write");
        tick("R9 no write");

        // R10: global write overrides inactive byte controls.
        idle(); gw_n = 0; din = 32'hCAFE_0001; tick("R10 global");
        idle(); tick("R10 readback");

        // R4: processor load is read-only; it also wins over the controller strobe.
        addr = 10'h012; adsp_n = 0; gw_n = 0; din = 32'h5555_5555; tick("R4 read-only");
        idle(); tick("R4 read-only");
        addr = 10'h013; adsp_n = 0; adsc_n = 0; gw_n = 0; din = 32'h6666_6666;
        tick("R4 both strobes");
        idle(); tick("R4 both strobes");
        addr = 10'h017; adsp_n = 0; ce1_n = 1; tick("R4 adsp ignored");
        idle(); tick("R4 adsp ignored");

        // R2: deselect via ce2 and via ce3_n.
        addr = 10'h010; adsc_n = 0; ce2 = 0; tick("R2 deselect ce2");
        idle(); adv_n = 0; tick("R2 stays off");
        idle(); addr = 10'h011; adsc_n = 0; tick("R3 reselect");
        idle(); adsc_n = 0; ce3_n = 1; gw_n = 0; tick("R2 deselect ce3");
        idle(); addr = 10'h010; adsc_n = 0; tick("R3 reselect");
        idle(); tick("R7 hold");

        @(negedge clk); @(negedge clk);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        end
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        end
        $finish;
    end
endmodule